// File: doc/BRIEF.md
# Masked Predicate Population Counter

This block counts the active elements of a scalable-vector predicate. A predicate carries one bit for each byte of vector data, so a vector of N bytes has an N-bit predicate. The block takes a source predicate and a governing predicate, both of the full maximum width, together with a 2-bit element-size code and a length code. It returns a 64-bit count of the elements that are active in both predicates. Only the lowest predicate bit of each element is counted. All other bits are ignored, and so are all bits at or beyond the active predicate length.

A request enters through a valid/ready handshake. When it is accepted, the block masks both predicates at once. It then walks the masked predicate in fixed-width chunks, one chunk per cycle, and adds each chunk's population count to an accumulator. The number of chunks is the active length divided by the chunk width, rounded up. The result is offered on a valid/ready output. While the output is not taken, the block keeps it stable and accepts no new request. The request side is therefore back-pressured until the result leaves.

Top module: `pred_popcount`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `count` is 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From that edge until the result is taken, `in_ready` is 0, and any `in_valid` activity in that time is ignored.
- R3: The element-size code selects how many predicate bits make up one element. Code 0 counts every bit, code 1 counts only bit indices divisible by 2, code 2 only those divisible by 4, and code 3 only those divisible by 8.
- R4: `count` equals the number of bit positions i that meet all of these: i is below the active length, i is allowed by R3, `src_pred[i]` is 1 and `gov_pred[i]` is 1.
- R5: The active length in bits is 8 × (`len_code` + 2). Predicate bits at or above that length do not contribute to the count.
- R6: A `len_code` whose length would exceed `MAX_BITS` is treated as `MAX_BITS`. With the default parameters, code 31 counts over 256 bits.
- R7: `out_valid` rises exactly K clock edges after the accepting edge, where K = ceil(active length / `CHUNK_W`). With the defaults, K is 1 for lengths up to 64 bits and 4 for 256 bits.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `count` stays unchanged. The edge where both are 1 retires the result, and `in_ready` is 1 after that edge.
- R9: `count` is 64 bits wide. Every bit above the count value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, able to accept a request |
| src_pred | input | MAX_BITS | Source predicate, bit i covers byte i |
| gov_pred | input | MAX_BITS | Governing predicate |
| elem_size | input | 2 | Element-size code (0..3 → 1/2/4/8-byte elements) |
| len_code | input | CODE_W | Active predicate length in bytes minus 2 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| count | output | 64 | Number of active elements |

## Verification
The embedded assertions check on every cycle that `in_ready` and `out_valid` are never high together, and that acceptance drops `in_ready`. They also check that a stalled result holds, that the chunk index stays below the latched chunk count, and that the result never exceeds the predicate width. The exact count for each element size, the length masking and clamping, the chunk-dependent latency, and the fact that input activity during a busy period is ignored can only be shown by the bench's scenarios. For those, a behavioural model predicts the handshake state and the count on every clock across directed and random predicates.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pcnt_state_e;

  // Distance between element-representative predicate bits for a size code.
  function automatic int elem_stride(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/pcnt_prep.sv
module pcnt_prep #(
  parameter int MAX_BITS = 256,
  parameter int CHUNK_W  = 64,
  parameter int CODE_W   = 5,
  parameter int PAD_BITS = 256,
  parameter int NCH_W    = 3
) (
  input  logic [MAX_BITS-1:0] src_pred,
  input  logic [MAX_BITS-1:0] gov_pred,
  input  logic [1:0]          elem_size,
  input  logic [CODE_W-1:0]   len_code,
  output logic [PAD_BITS-1:0] masked,
  output logic [NCH_W-1:0]    nchunk
);
  import pcnt_pkg::*;

  localparam int MAX_BYTES = MAX_BITS / 8;

  logic [PAD_BITS-1:0] src_ext;
  logic [PAD_BITS-1:0] gov_ext;
  int                  act_bytes;
  int                  act_bits;
  int                  stride;

  assign src_ext = PAD_BITS'(src_pred);
  assign gov_ext = PAD_BITS'(gov_pred);

  // Active length from the descriptor, clamped to the configured width.
  always_comb begin
    act_bytes = int'(len_code) + 2;
    if (act_bytes > MAX_BYTES) act_bytes = MAX_BYTES;
    act_bits = act_bytes * 8;
    nchunk   = NCH_W'((act_bits + CHUNK_W - 1) / CHUNK_W);
  end

  // Keep only representative bits inside the active length.
  always_comb begin
    stride = elem_stride(elem_size);
    for (int i = 0; i < PAD_BITS; i++) begin
      masked[i] = src_ext[i] & gov_ext[i] & (i < act_bits) &
                  ((i & (stride - 1)) == 0);
    end
  end
endmodule

// File: rtl/pcnt_popcount.sv
module pcnt_popcount #(
  parameter int W     = 64,
  parameter int OUT_W = 7
) (
  input  logic [W-1:0]     bits,
  output logic [OUT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + OUT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/pred_popcount.sv
module pred_popcount #(
  parameter int MAX_BITS = 256,
  parameter int CHUNK_W  = 64,
  parameter int CODE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] src_pred,
  input  logic [MAX_BITS-1:0] gov_pred,
  input  logic [1:0]          elem_size,
  input  logic [CODE_W-1:0]   len_code,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [63:0]         count
);
  import pcnt_pkg::*;

  localparam int NCHUNK   = (MAX_BITS + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_BITS = NCHUNK * CHUNK_W;
  localparam int IDX_W    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int NCH_W    = $clog2(NCHUNK + 1);
  localparam int PC_W     = $clog2(CHUNK_W + 1);

  pcnt_state_e         state_q;
  logic [PAD_BITS-1:0] pred_q;
  logic [NCH_W-1:0]    nchunk_q;
  logic [IDX_W-1:0]    idx_q;
  logic [63:0]         acc_q;

  logic [PAD_BITS-1:0] masked;
  logic [NCH_W-1:0]    nchunk;
  logic [CHUNK_W-1:0]  chunk;
  logic [PC_W-1:0]     chunk_cnt;
  logic                accept;
  logic                last_chunk;

  pcnt_prep #(
    .MAX_BITS(MAX_BITS), .CHUNK_W(CHUNK_W), .CODE_W(CODE_W),
    .PAD_BITS(PAD_BITS), .NCH_W(NCH_W)
  ) u_prep (
    .src_pred (src_pred),
    .gov_pred (gov_pred),
    .elem_size(elem_size),
    .len_code (len_code),
    .masked   (masked),
    .nchunk   (nchunk)
  );

  assign chunk = pred_q[idx_q*CHUNK_W +: CHUNK_W];

  pcnt_popcount #(.W(CHUNK_W), .OUT_W(PC_W)) u_pop (
    .bits(chunk),
    .ones(chunk_cnt)
  );

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_DONE);
  assign count      = acc_q;
  assign accept     = in_valid && in_ready;
  assign last_chunk = ((int'(idx_q) + 1) == int'(nchunk_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pred_q   <= '0;
      nchunk_q <= '0;
      idx_q    <= '0;
      acc_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pred_q   <= masked;
            nchunk_q <= nchunk;
            idx_q    <= '0;
            acc_q    <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q <= acc_q + 64'(chunk_cnt);
          if (last_chunk) state_q <= ST_DONE;
          else            idx_q   <= idx_q + 1'b1;
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the two handshake sides are never open together
  assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R2: acceptance closes the request side
  assert_accept_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8: a stalled result holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(count)));

  // R7: the walk never passes the latched chunk count
  assert_chunk_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (int'(idx_q) < int'(nchunk_q)));

  // R4: the count cannot exceed the predicate width
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (count <= 64'(MAX_BITS)));
endmodule

// File: tb/test_pred_popcount.sv
module test_pred_popcount;
  localparam int MAX_BITS = 256;
  localparam int CHUNK_W  = 64;
  localparam int CODE_W   = 5;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [MAX_BITS-1:0] src_pred = '0;
  logic [MAX_BITS-1:0] gov_pred = '0;
  logic [1:0]          elem_size = '0;
  logic [CODE_W-1:0]   len_code = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic [63:0]         count;

  int    total = 0;
  int    bad = 0;
  bit    rand_rdy = 1'b0;
  string cur_tag = "R4";

  // behavioural model state
  int      m_phase = 0;   // 0 idle, 1 busy, 2 result offered
  int      m_left = 0;
  longint  m_exp = 0;
  string   m_tag = "R4";

  always #5 clk = ~clk;

  pred_popcount #(.MAX_BITS(MAX_BITS), .CHUNK_W(CHUNK_W), .CODE_W(CODE_W)) i_pred_popcount (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_pred(src_pred), .gov_pred(gov_pred), .elem_size(elem_size),
    .len_code(len_code), .out_valid(out_valid), .out_ready(out_ready),
    .count(count)
  );

  function automatic int act_bits(input int code);
    int b;
    b = (code + 2) * 8;
    if (b > MAX_BITS) b = MAX_BITS;
    return b;
  endfunction

  function automatic longint ref_count(input logic [MAX_BITS-1:0] s,
                                       input logic [MAX_BITS-1:0] g,
                                       input int esz, input int code);
    longint n = 0;
    int step = 1;
    for (int k = 0; k < esz; k++) step = step * 2;
    for (int i = 0; i < act_bits(code); i = i + step)
      if (s[i] && g[i]) n++;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0;
      m_left  <= 0;
    end else begin
      case (m_phase)
        0: if (in_valid) begin
             m_phase <= 1;
             m_left  <= (act_bits(int'(len_code)) + CHUNK_W - 1) / CHUNK_W;
             m_exp   <= ref_count(src_pred, gov_pred, int'(elem_size), int'(len_code));
             m_tag   <= cur_tag;
           end
        1: begin
             if (m_left == 1) m_phase <= 2;
             m_left <= m_left - 1;
           end
        default: if (out_ready) m_phase <= 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (m_phase == 0), "R2", longint'(in_ready), longint'(m_phase == 0));
      check(out_valid == (m_phase == 2), "R7/R8", longint'(out_valid), longint'(m_phase == 2));
      if (m_phase == 2) begin
        // R9: full 64-bit compare, upper bits must be zero
        check(count === 64'(m_exp), m_tag, longint'(count), m_exp);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rand_rdy) out_ready = 1'($urandom % 2);
    end
  end

  task automatic send(input logic [MAX_BITS-1:0] s, input logic [MAX_BITS-1:0] g,
                      input int esz, input int code, input string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    src_pred  = s;
    gov_pred  = g;
    elem_size = 2'(esz);
    len_code  = CODE_W'(code);
    cur_tag   = tag;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (m_phase != 0) @(negedge clk);
  endtask

  function automatic logic [MAX_BITS-1:0] rnd_pred();
    logic [MAX_BITS-1:0] v;
    for (int w = 0; w < MAX_BITS / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [MAX_BITS-1:0] ones;
    logic [MAX_BITS-1:0] alt;
    ones = '1;
    alt  = {(MAX_BITS/8){8'h55}};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready === 1'b1, "R1", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    check(count === 64'd0, "R1", longint'(count), 0);
    rst_n = 1'b1;

    // R5: shortest length, R3: each element size (16/8/4/2 expected)
    send(ones, ones, 0, 0, "R5");
    send(ones, ones, 1, 0, "R3");
    send(ones, ones, 2, 0, "R3");
    send(ones, ones, 3, 0, "R3");
    // R6: clamped and maximum lengths
    send(ones, ones, 0, 31, "R6");
    send(ones, ones, 0, 30, "R6");
    // R7: one-chunk and two-chunk boundaries
    send(ones, ones, 0, 6, "R7");
    send(ones, ones, 0, 7, "R7");
    // R4: governing predicate masks, patterned source
    send(ones, '0, 0, 30, "R4");
    send(alt, ones, 0, 30, "R4");
    send(alt, ones, 1, 30, "R3");
    send(~alt, ones, 1, 30, "R3");
    drain();

    // R8: stalled result, R2: requests while busy are ignored
    out_ready = 1'b0;
    send(ones, alt, 0, 30, "R8");
    src_pred = '0;
    len_code = '0;
    in_valid = 1'b1;
    repeat (8) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // random traffic with random consumer stalls
    rand_rdy = 1'b1;
    for (int n = 0; n < 60; n++) begin
      send(rnd_pred(), rnd_pred(), int'($urandom % 4), int'($urandom % 32), "R4");
    end
    rand_rdy = 1'b0;
    out_ready = 1'b1;
    drain();
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule